// File: doc/BRIEF.md
# Operating Point Transition Sequencer

This block moves the core between its running operating point and a reduced one when the power state controller asks for a deeper sleep level. An operating point has two parts: the core clock multiplier (ratio) and the voltage identifier (VID) sent to the regulator. The two steps run in opposite orders. On the way down the multiplier drops first and the voltage follows. On the way up the voltage rises first, and the core keeps running at the low multiplier until the voltage has settled. Only the core multiplier changes. The bus clock that the multiplier scales is not touched.

Each multiplier step finishes only after the clock generator reports lock. Each voltage step finishes only after a settle countdown has run out. The length of that countdown is a programmable input. At the start of every entry the current operating point is copied into save registers, and the exit sequence restores from them. While the state controller is servicing a snoop in the low state, the reduced point stays unchanged. An exit request that comes in during entry, or during a snoop, is remembered and carried out as soon as it is allowed.

Top module: `oppt_sequencer`

## Requirements
- R1: A synchronous reset sets ratio_out to DEF_RATIO (12) and vid_out to DEF_VID (40), returns the sequencer to idle and drives enter_done and exit_done low. This holds even when reset arrives in the middle of a sequence.
- R2: An enter_req sampled in idle does three things at that edge: it saves the current point, captures low_ratio and low_vid, and moves ratio_out to the captured low ratio. vid_out does not change at that edge. Later changes on low_ratio and low_vid have no effect on the sequence.
- R3: vid_out moves to the captured low VID only at the edge after ratio_lock is sampled high during the entry ratio step. It never moves before that edge.
- R4: The VID step loads settle_cycles = S. enter_done rises exactly S+1 cycles after vid_out changes, and it stays high while the sequencer rests in the low state.
- R5: An exit_req in the low state, with snoop_hold low, takes effect at one edge: vid_out returns to the saved VID and enter_done falls. ratio_out stays at the low ratio.
- R6: ratio_out returns to the saved ratio exactly S+1 cycles after the VID restore. exit_done is a one-cycle pulse that appears at the edge after ratio_lock is sampled high. At that point both outputs equal the saved point.
- R7: While snoop_hold is high in the low state, ratio_out and vid_out do not change, and an exit_req is held pending. The exit starts at the first edge at which snoop_hold is sampled low.
- R8: An exit_req that arrives during the entry steps is held. enter_done is then high for exactly one cycle, and the VID restore happens at the edge where enter_done falls.
- R9: An exit_req sampled in idle has no effect and is not remembered. An enter_req sampled outside idle has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core control clock |
| rst | input | 1 | Synchronous active-high reset |
| enter_req | input | 1 | Request to move to the reduced operating point |
| exit_req | input | 1 | Request to return to the saved operating point |
| snoop_hold | input | 1 | High while the state controller services a snoop in the low state |
| ratio_lock | input | 1 | Clock generator reports lock at the current multiplier |
| low_ratio | input | RATIO_W | Reduced multiplier, captured on entry |
| low_vid | input | VID_W | Reduced voltage code, captured on entry |
| settle_cycles | input | CNT_W | Voltage settle length, loaded at each VID step |
| ratio_out | output | RATIO_W | Core clock multiplier in use |
| vid_out | output | VID_W | Voltage code sent to the regulator |
| enter_done | output | 1 | High while resting at the reduced point |
| exit_done | output | 1 | One-cycle pulse when the restore sequence completes |

## Verification
Some rules are checked by assertions on every cycle. These cover the ordering rules: the voltage stays put while the multiplier waits for lock, nothing moves under snoop_hold, the multiplier is restored only after the voltage is back, the done flags are never high together, and exit_done lasts one cycle. Other behaviour can only be shown by the bench scenarios. This includes the exact cycle gaps set by the settle count and the lock delay, an exit held over an entry in progress or a snoop window, requests that must be ignored, target values that change after capture, and reset in the middle of a sequence.

// File: rtl/oppt_pkg.sv
package oppt_pkg;

  typedef enum logic [2:0] {
    ST_IDLE      = 3'd0,
    ST_ENT_RATIO = 3'd1,
    ST_ENT_VID   = 3'd2,
    ST_LOW       = 3'd3,
    ST_EXT_VID   = 3'd4,
    ST_EXT_RATIO = 3'd5
  } seq_state_e;

  function automatic logic exit_can_queue(seq_state_e s);
    return (s == ST_ENT_RATIO) || (s == ST_ENT_VID) || (s == ST_LOW);
  endfunction

endpackage

// File: rtl/oppt_settle_timer.sv
module oppt_settle_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expired = (cnt_q == '0);

  // R4: without a load, the count only ever moves down
  a_r4_count_down: assert property (@(posedge clk) disable iff (rst)
    (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/oppt_step_fsm.sv
module oppt_step_fsm
  import oppt_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       enter_req,
  input  logic       exit_req,
  input  logic       snoop_hold,
  input  logic       ratio_lock,
  input  logic       settle_done,
  output seq_state_e state,
  output logic       cap_entry,
  output logic       set_low_vid,
  output logic       restore_vid,
  output logic       restore_ratio,
  output logic       timer_load,
  output logic       enter_done,
  output logic       exit_done
);

  seq_state_e state_q, state_d;
  logic       pend_q;
  logic       go_exit;

  assign go_exit = (state_q == ST_LOW) && (exit_req || pend_q) && !snoop_hold;

  always_comb begin
    state_d       = state_q;
    cap_entry     = 1'b0;
    set_low_vid   = 1'b0;
    restore_vid   = 1'b0;
    restore_ratio = 1'b0;
    timer_load    = 1'b0;
    unique case (state_q)
      ST_IDLE: if (enter_req) begin
        cap_entry = 1'b1;
        state_d   = ST_ENT_RATIO;
      end
      ST_ENT_RATIO: if (ratio_lock) begin
        set_low_vid = 1'b1;
        timer_load  = 1'b1;
        state_d     = ST_ENT_VID;
      end
      ST_ENT_VID: if (settle_done) state_d = ST_LOW;
      ST_LOW: if (go_exit) begin
        restore_vid = 1'b1;
        timer_load  = 1'b1;
        state_d     = ST_EXT_VID;
      end
      ST_EXT_VID: if (settle_done) begin
        restore_ratio = 1'b1;
        state_d       = ST_EXT_RATIO;
      end
      ST_EXT_RATIO: if (ratio_lock) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      pend_q     <= 1'b0;
      enter_done <= 1'b0;
      exit_done  <= 1'b0;
    end else begin
      state_q   <= state_d;
      exit_done <= (state_q == ST_EXT_RATIO) && ratio_lock;
      if (go_exit)
        pend_q <= 1'b0;
      else if (exit_req && exit_can_queue(state_q))
        pend_q <= 1'b1;
      if (state_q == ST_ENT_VID && settle_done)
        enter_done <= 1'b1;
      else if (go_exit)
        enter_done <= 1'b0;
    end
  end

  assign state = state_q;

  // R9: a request seen in idle never leaves an exit pending
  a_r9_no_idle_pend: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_IDLE) |=> !pend_q);

  // R6: the completion flag lasts one cycle
  a_r6_exit_pulse: assert property (@(posedge clk) disable iff (rst)
    exit_done |=> !exit_done);

endmodule

// File: rtl/oppt_point_regs.sv
module oppt_point_regs #(
  parameter int RATIO_W   = 6,
  parameter int VID_W     = 7,
  parameter int DEF_RATIO = 12,
  parameter int DEF_VID   = 40
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cap_entry,
  input  logic               set_low_vid,
  input  logic               restore_vid,
  input  logic               restore_ratio,
  input  logic [RATIO_W-1:0] low_ratio_in,
  input  logic [VID_W-1:0]   low_vid_in,
  output logic [RATIO_W-1:0] ratio_out,
  output logic [VID_W-1:0]   vid_out
);

  localparam logic [RATIO_W-1:0] RST_RATIO = RATIO_W'(DEF_RATIO);
  localparam logic [VID_W-1:0]   RST_VID   = VID_W'(DEF_VID);

  logic [RATIO_W-1:0] ratio_q, save_ratio_q;
  logic [VID_W-1:0]   vid_q, save_vid_q, tgt_vid_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ratio_q      <= RST_RATIO;
      save_ratio_q <= '0;
    end else if (cap_entry) begin
      save_ratio_q <= ratio_q;
      ratio_q      <= low_ratio_in;
    end else if (restore_ratio) begin
      ratio_q <= save_ratio_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vid_q      <= RST_VID;
      save_vid_q <= '0;
      tgt_vid_q  <= '0;
    end else if (cap_entry) begin
      save_vid_q <= vid_q;
      tgt_vid_q  <= low_vid_in;
    end else if (set_low_vid) begin
      vid_q <= tgt_vid_q;
    end else if (restore_vid) begin
      vid_q <= save_vid_q;
    end
  end

  assign ratio_out = ratio_q;
  assign vid_out   = vid_q;

  // R2: the multiplier step at entry leaves the voltage alone
  a_r2_entry_keeps_vid: assert property (@(posedge clk) disable iff (rst)
    cap_entry |=> $stable(vid_q));

  // R6: the multiplier is restored only once the voltage is back
  a_r6_vid_before_ratio: assert property (@(posedge clk) disable iff (rst)
    restore_ratio |-> (vid_q == save_vid_q));

  // R5: the voltage restore leaves the low multiplier in place
  a_r5_ratio_held: assert property (@(posedge clk) disable iff (rst)
    restore_vid |=> $stable(ratio_q));

endmodule

// File: rtl/oppt_sequencer.sv
module oppt_sequencer
  import oppt_pkg::*;
#(
  parameter int RATIO_W   = 6,
  parameter int VID_W     = 7,
  parameter int CNT_W     = 8,
  parameter int DEF_RATIO = 12,
  parameter int DEF_VID   = 40
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               enter_req,
  input  logic               exit_req,
  input  logic               snoop_hold,
  input  logic               ratio_lock,
  input  logic [RATIO_W-1:0] low_ratio,
  input  logic [VID_W-1:0]   low_vid,
  input  logic [CNT_W-1:0]   settle_cycles,
  output logic [RATIO_W-1:0] ratio_out,
  output logic [VID_W-1:0]   vid_out,
  output logic               enter_done,
  output logic               exit_done
);

  seq_state_e state;
  logic cap_entry, set_low_vid, restore_vid, restore_ratio, timer_load;
  logic settle_done;

  oppt_step_fsm u_fsm (
    .clk          (clk),
    .rst          (rst),
    .enter_req    (enter_req),
    .exit_req     (exit_req),
    .snoop_hold   (snoop_hold),
    .ratio_lock   (ratio_lock),
    .settle_done  (settle_done),
    .state        (state),
    .cap_entry    (cap_entry),
    .set_low_vid  (set_low_vid),
    .restore_vid  (restore_vid),
    .restore_ratio(restore_ratio),
    .timer_load   (timer_load),
    .enter_done   (enter_done),
    .exit_done    (exit_done)
  );

  oppt_settle_timer #(.CNT_W(CNT_W)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .load    (timer_load),
    .load_val(settle_cycles),
    .expired (settle_done)
  );

  oppt_point_regs #(
    .RATIO_W  (RATIO_W),
    .VID_W    (VID_W),
    .DEF_RATIO(DEF_RATIO),
    .DEF_VID  (DEF_VID)
  ) u_regs (
    .clk          (clk),
    .rst          (rst),
    .cap_entry    (cap_entry),
    .set_low_vid  (set_low_vid),
    .restore_vid  (restore_vid),
    .restore_ratio(restore_ratio),
    .low_ratio_in (low_ratio),
    .low_vid_in   (low_vid),
    .ratio_out    (ratio_out),
    .vid_out      (vid_out)
  );

  // R1: reset leaves the default point and no done flag
  a_r1_reset_point: assert property (@(posedge clk)
    rst |=> (ratio_out == RATIO_W'(DEF_RATIO) && vid_out == VID_W'(DEF_VID)
             && !enter_done && !exit_done));

  // R3: the voltage waits for multiplier lock
  a_r3_vid_waits_lock: assert property (@(posedge clk) disable iff (rst)
    (state == ST_ENT_RATIO && !ratio_lock) |=> $stable(vid_out));

  // R4: no completion while the settle count runs
  a_r4_settle_gate: assert property (@(posedge clk) disable iff (rst)
    (state == ST_ENT_VID && !settle_done) |=> !enter_done);

  // R7: the reduced point is frozen during a snoop
  a_r7_snoop_freeze: assert property (@(posedge clk) disable iff (rst)
    (state == ST_LOW && snoop_hold) |=> ($stable(vid_out) && $stable(ratio_out)));

  // R6: the two completion flags never overlap
  a_r6_done_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(enter_done && exit_done));

endmodule

// File: tb/tb_oppt_sequencer.sv
`timescale 1ns/1ps
module tb_oppt_sequencer;

  localparam int RW = 6, VW = 7, CW = 8;
  localparam int DEF_R = 12, DEF_V = 40;

  typedef struct packed {
    int settle; int lr; int lv; int lockd; int snoop; int early;
  } vec_t;

  localparam int NV = 5;
  localparam vec_t VECS [NV] = '{
    '{3, 6, 20, 2, 0, 0},
    '{0, 4, 18, 0, 0, 0},
    '{5, 8, 25, 1, 4, 0},
    '{2, 5, 22, 3, 0, 1},
    '{1, 7, 30, 0, 1, 0}
  };

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst = 1'b1, enter_req = 1'b0, exit_req = 1'b0, snoop_hold = 1'b0;
  logic ratio_lock;
  logic [RW-1:0] low_ratio = '0;
  logic [VW-1:0] low_vid = '0;
  logic [CW-1:0] settle_cycles = '0;
  logic [RW-1:0] ratio_out;
  logic [VW-1:0] vid_out;
  logic enter_done, exit_done;

  oppt_sequencer dut (
    .clk(clk), .rst(rst), .enter_req(enter_req), .exit_req(exit_req),
    .snoop_hold(snoop_hold), .ratio_lock(ratio_lock), .low_ratio(low_ratio),
    .low_vid(low_vid), .settle_cycles(settle_cycles), .ratio_out(ratio_out),
    .vid_out(vid_out), .enter_done(enter_done), .exit_done(exit_done)
  );

  // clock generator lock model: lock drops on a multiplier change, returns after lock_dly edges
  int lock_dly = 0;
  int lock_cnt = 0;
  logic [RW-1:0] seen_ratio = '0;
  always @(posedge clk) begin
    if (rst || ratio_out != seen_ratio) begin
      seen_ratio <= ratio_out;
      lock_cnt   <= lock_dly;
    end else if (lock_cnt != 0) begin
      lock_cnt <= lock_cnt - 1;
    end
  end
  assign ratio_lock = (ratio_out == seen_ratio) && (lock_cnt == 0);

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic run_vec(input vec_t v);
    int n;
    settle_cycles = CW'(v.settle);
    low_ratio = RW'(v.lr);
    low_vid = VW'(v.lv);
    lock_dly = v.lockd;
    enter_req = 1'b1;
    step();
    enter_req = 1'b0;
    low_ratio = '0;               // later target changes must not matter (R2)
    low_vid = '0;
    chk(ratio_out == RW'(v.lr), "R2", "ratio after enter", int'(ratio_out), v.lr);
    chk(vid_out == VW'(DEF_V), "R2", "vid after enter", int'(vid_out), DEF_V);
    n = 0;
    if (v.early != 0) begin
      exit_req = 1'b1;
      step();
      exit_req = 1'b0;
      n = 1;
    end
    while (vid_out == VW'(DEF_V) && n < 300) begin step(); n++; end
    chk(n == v.lockd + 2, "R3", "cycles ratio->vid", n, v.lockd + 2);
    chk(vid_out == VW'(v.lv), "R3", "low vid", int'(vid_out), v.lv);
    n = 0;
    while (!enter_done && n < 300) begin step(); n++; end
    chk(n == v.settle + 1, "R4", "cycles vid->enter_done", n, v.settle + 1);
    if (v.early != 0) begin
      step();
      chk(!enter_done, "R8", "enter_done width", int'(enter_done), 0);
      chk(vid_out == VW'(DEF_V), "R8", "vid restore", int'(vid_out), DEF_V);
      chk(ratio_out == RW'(v.lr), "R8", "ratio held low", int'(ratio_out), v.lr);
    end else begin
      repeat (3) step();
      chk(enter_done && vid_out == VW'(v.lv), "R4", "rest at low vid", int'(vid_out), v.lv);
      if (v.snoop > 0) begin
        snoop_hold = 1'b1;
        exit_req = 1'b1;
        step();
        exit_req = 1'b0;
        repeat (v.snoop - 1) step();
        chk(vid_out == VW'(v.lv) && ratio_out == RW'(v.lr) && enter_done,
            "R7", "vid during snoop", int'(vid_out), v.lv);
        snoop_hold = 1'b0;
        step();
        chk(vid_out == VW'(DEF_V), "R7", "vid after snoop", int'(vid_out), DEF_V);
      end else begin
        exit_req = 1'b1;
        step();
        exit_req = 1'b0;
        chk(vid_out == VW'(DEF_V), "R5", "vid restore", int'(vid_out), DEF_V);
        chk(ratio_out == RW'(v.lr), "R5", "ratio held", int'(ratio_out), v.lr);
        chk(!enter_done, "R5", "enter_done fall", int'(enter_done), 0);
      end
    end
    n = 0;
    while (ratio_out != RW'(DEF_R) && n < 300) begin step(); n++; end
    chk(n == v.settle + 1, "R6", "cycles vid->ratio restore", n, v.settle + 1);
    n = 0;
    while (!exit_done && n < 300) begin step(); n++; end
    chk(n == v.lockd + 2, "R6", "cycles ratio->exit_done", n, v.lockd + 2);
    chk(vid_out == VW'(DEF_V) && ratio_out == RW'(DEF_R), "R6", "restored ratio",
        int'(ratio_out), DEF_R);
    step();
    chk(!exit_done, "R6", "exit_done width", int'(exit_done), 0);
    repeat (2) step();
  endtask

  initial begin
    int n;
    repeat (3) step();
    rst = 1'b0;
    step();
    chk(ratio_out == RW'(DEF_R), "R1", "reset ratio", int'(ratio_out), DEF_R);
    chk(vid_out == VW'(DEF_V), "R1", "reset vid", int'(vid_out), DEF_V);
    chk(!enter_done && !exit_done, "R1", "reset done flags",
        int'(enter_done) + int'(exit_done), 0);

    for (int i = 0; i < NV; i++) run_vec(VECS[i]);

    // R9: exit in idle does nothing and is not remembered
    exit_req = 1'b1;
    step();
    exit_req = 1'b0;
    repeat (4) begin
      step();
      chk(vid_out == VW'(DEF_V) && !exit_done && !enter_done, "R9", "idle exit ignored",
          int'(vid_out), DEF_V);
    end

    // R9: enter while resting low is ignored; also no stale exit from idle
    settle_cycles = 8'd1; low_ratio = 6'd5; low_vid = 7'd21; lock_dly = 0;
    enter_req = 1'b1;
    step();
    enter_req = 1'b0;
    n = 0;
    while (!enter_done && n < 300) begin step(); n++; end
    low_ratio = 6'd3; low_vid = 7'd9;
    enter_req = 1'b1;
    step();
    enter_req = 1'b0;
    repeat (3) step();
    chk(ratio_out == 6'd5 && vid_out == 7'd21 && enter_done, "R9",
        "enter in low ignored", int'(ratio_out), 5);
    exit_req = 1'b1;
    step();
    exit_req = 1'b0;
    n = 0;
    while (!exit_done && n < 300) begin step(); n++; end
    chk(ratio_out == RW'(DEF_R) && vid_out == VW'(DEF_V), "R9", "exit after ignored enter",
        int'(vid_out), DEF_V);
    repeat (2) step();

    // R1: reset in the middle of entry
    settle_cycles = 8'd6; low_ratio = 6'd4; low_vid = 7'd17; lock_dly = 0;
    enter_req = 1'b1;
    step();
    enter_req = 1'b0;
    repeat (3) step();
    rst = 1'b1;
    step();
    rst = 1'b0;
    chk(ratio_out == RW'(DEF_R), "R1", "mid reset ratio", int'(ratio_out), DEF_R);
    chk(vid_out == VW'(DEF_V), "R1", "mid reset vid", int'(vid_out), DEF_V);
    repeat (10) begin
      step();
      chk(!enter_done && ratio_out == RW'(DEF_R), "R1", "idle after reset",
          int'(enter_done), 0);
    end

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule